// File: doc/BRIEF.md
# Interrupt and Sleep Wake-up Controller

This block gathers the four event sources of a small microcontroller core: a change on any bit of the 8-bit general-purpose input port, a falling edge on either of two active-low external interrupt pins, and any change of the analog comparator output. Each source sets a sticky flag. Per-source interrupt enables and a global enable decide whether an interrupt request goes to the core. A separate set of per-source wake enables decides whether a flag ends sleep.

When the core leaves sleep, the block reports whether execution should take the interrupt vector or carry on with the next instruction. The global enable is set and cleared by dedicated strobes from the core's enable and disable instructions. The same block owns the reset request. Power-on, a low level on the reset pin and a watchdog time-out each hold the core in reset for a parameterised number of cycles. A small status code records whether the last restart came from one of these resets or from a wake-up.

All inputs from pins and the comparator pass through two-flop synchronisers. Every output is a plain control level or a one-cycle strobe. Saving the core's context on interrupt entry is done by a separate shadow register set, not by this block.

Top module: `irq_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `rst_req` is 1, `flags`, `global_en`, `sleeping`, `wake` and `irq` are 0, and `rst_cause` is 0 (power-on). After `rst_n` rises, `rst_req` stays 1 for exactly `HOLD_CYCLES` rising clock edges and then falls.
- R2: A low level on `rst_pin_n` or a one-cycle `wdt_timeout` pulse reloads the hold count, so `rst_req` rises again. `rst_cause` becomes 1 for the pin and 2 for the watchdog; the pin wins if both happen together. While `rst_req` is 1, all flags, the global enable and the sleep state are cleared.
- R3: `flags[0]` is set when the synchronised port value differs from a snapshot. The snapshot is reloaded on every `port_rd` strobe. Until the port is read, clearing the flag does not stick.
- R4: A falling edge on `ext_pin_n[0]` sets `flags[1]`, and a falling edge on `ext_pin_n[1]` sets `flags[2]`. Rising edges set nothing.
- R5: A change of `cmp_out` in either direction sets `flags[3]`.
- R6: A flag stays set until software clears it with the matching `flag_clr` bit. If a new event and a clear arrive in the same cycle, the flag stays set.
- R7: `irq` is 1 exactly when the block is awake, `global_en` is 1 and some flag has its `int_en` bit set. `wake_en` has no effect on `irq`.
- R8: `gie_set` sets `global_en`. `gie_clr` or `irq_ack` clears it. A clear wins over a set in the same cycle.
- R9: `sleep_cmd` puts the block into sleep (`sleeping`=1) and forces `irq` low. Sleep ends only when a flag has its `wake_en` bit set. An interrupt enable alone never ends sleep.
- R10: Leaving sleep produces a one-cycle `wake` pulse. Alongside it, `wake_vector` is 1 if `global_en` is 1 and some flag has its `int_en` bit set (take the vector), and 0 otherwise (continue). `rst_cause` becomes 3 (wake-up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | External reset pin level, active low |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| port_in | input | PORT_W | Input port levels |
| port_rd | input | 1 | Port read strobe; reloads the change snapshot |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| cmp_out | input | 1 | Comparator output level |
| int_en | input | 4 | Per-source interrupt enables |
| wake_en | input | 4 | Per-source wake enables |
| flag_clr | input | 4 | Per-flag software clear strobes |
| gie_set | input | 1 | Global interrupt enable set strobe |
| gie_clr | input | 1 | Global interrupt enable clear strobe |
| irq_ack | input | 1 | Core took the vector; clears the global enable |
| sleep_cmd | input | 1 | Enter sleep strobe |
| flags | output | 4 | Event flags: change, ext0, ext1, comparator |
| irq | output | 1 | Interrupt request to the core |
| global_en | output | 1 | Current global interrupt enable |
| sleeping | output | 1 | Block is in sleep |
| wake | output | 1 | One-cycle pulse on leaving sleep |
| wake_vector | output | 1 | With `wake`: 1 = jump to vector, 0 = continue |
| rst_req | output | 1 | Reset request to the core |
| rst_cause | output | 2 | 0 power-on, 1 pin, 2 watchdog, 3 wake-up |

## Verification
Some properties are checked on every cycle by assertions:
- `irq` is never raised without the global enable and an enabled pending flag, and never while asleep.
- `wake` only follows a sleeping cycle, and `wake_vector` never appears without it.
- A watchdog strobe always raises the reset request, and a reset always empties the flags and the sleep and enable state.
- Flags never drop without a clear or a reset.

Other behaviour can only be shown by the bench's scenarios, because it depends on the stimulus history:
- The exact hold length and the recorded cause codes.
- The need to read the port before a change flag will clear.
- That rising edges are ignored.
- The full grid of source, interrupt enable, wake enable and global enable, in both sleep and run mode, with its vector-or-continue outcome.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam int NSRC = 4;
  localparam int SRC_CHG  = 0;
  localparam int SRC_EXT0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_CMP  = 3;

  typedef enum logic [1:0] {
    CAUSE_POR  = 2'd0,
    CAUSE_PIN  = 2'd1,
    CAUSE_WDT  = 2'd2,
    CAUSE_WAKE = 2'd3
  } cause_e;
endpackage

// File: rtl/irqw_sync.sv
module irqw_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= INIT;
      q      <= INIT;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irqw_detect.sv
module irqw_detect
  import irqw_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic [PORT_W-1:0] port_s,
  input  logic              port_rd,
  input  logic [1:0]        ext_s,
  input  logic              cmp_s,
  input  logic [NSRC-1:0]   flag_clr,
  output logic [NSRC-1:0]   flags
);
  logic [PORT_W-1:0] snap;
  logic [1:0]        ext_d;
  logic              cmp_d;
  logic [NSRC-1:0]   set_v;

  assign set_v[SRC_CHG] = |(port_s ^ snap);
  assign set_v[SRC_CMP] = cmp_d ^ cmp_s;

  // External pins: a falling edge of the synchronised level sets the flag.
  for (genvar i = 0; i < 2; i++) begin : g_ext
    assign set_v[SRC_EXT0 + i] = ext_d[i] & ~ext_s[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap  <= '0;
      ext_d <= '1;
      cmp_d <= 1'b0;
      flags <= '0;
    end else if (clr_all) begin
      snap  <= port_s;
      ext_d <= ext_s;
      cmp_d <= cmp_s;
      flags <= '0;
    end else begin
      if (port_rd) snap <= port_s;
      ext_d <= ext_s;
      cmp_d <= cmp_s;
      // A new event wins over a clear in the same cycle.
      flags <= (flags & ~flag_clr) | set_v;
    end
  end
endmodule

// File: rtl/irqw_rstgen.sv
module irqw_rstgen
  import irqw_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_low,
  input  logic       wdt_timeout,
  input  logic       wake_evt,
  output logic       rst_req,
  output logic [1:0] rst_cause
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] cnt;
  cause_e        cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CW'(HOLD_CYCLES);
      cause_q <= CAUSE_POR;
    end else if (pin_low) begin
      cnt     <= CW'(HOLD_CYCLES);
      cause_q <= CAUSE_PIN;
    end else if (wdt_timeout) begin
      cnt     <= CW'(HOLD_CYCLES);
      cause_q <= CAUSE_WDT;
    end else begin
      if (cnt != '0) cnt <= cnt - CW'(1);
      if (wake_evt && cnt == '0) cause_q <= CAUSE_WAKE;
    end
  end

  assign rst_req   = (cnt != '0);
  assign rst_cause = cause_q;
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irqw_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin_n,
  input  logic              wdt_timeout,
  input  logic [PORT_W-1:0] port_in,
  input  logic              port_rd,
  input  logic [1:0]        ext_pin_n,
  input  logic              cmp_out,
  input  logic [3:0]        int_en,
  input  logic [3:0]        wake_en,
  input  logic [3:0]        flag_clr,
  input  logic              gie_set,
  input  logic              gie_clr,
  input  logic              irq_ack,
  input  logic              sleep_cmd,
  output logic [3:0]        flags,
  output logic              irq,
  output logic              global_en,
  output logic              sleeping,
  output logic              wake,
  output logic              wake_vector,
  output logic              rst_req,
  output logic [1:0]        rst_cause
);
  logic [PORT_W-1:0] port_s;
  logic [1:0]        ext_s;
  logic              cmp_s;
  logic              pin_s;
  logic              pend_irq;
  logic              pend_wake;
  logic              wake_evt;

  irqw_sync #(.W(PORT_W), .INIT('0)) u_port_sync (
    .clk(clk), .rst_n(rst_n), .d(port_in), .q(port_s));
  irqw_sync #(.W(2), .INIT(2'b11)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin_n), .q(ext_s));
  irqw_sync #(.W(1), .INIT(1'b0)) u_cmp_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_out), .q(cmp_s));
  irqw_sync #(.W(1), .INIT(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(rst_pin_n), .q(pin_s));

  irqw_detect #(.PORT_W(PORT_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .clr_all(rst_req),
    .port_s(port_s), .port_rd(port_rd), .ext_s(ext_s), .cmp_s(cmp_s),
    .flag_clr(flag_clr), .flags(flags));

  irqw_rstgen #(.HOLD_CYCLES(HOLD_CYCLES)) u_rstgen (
    .clk(clk), .rst_n(rst_n), .pin_low(~pin_s), .wdt_timeout(wdt_timeout),
    .wake_evt(wake_evt), .rst_req(rst_req), .rst_cause(rst_cause));

  assign pend_irq  = |(flags & int_en);
  assign pend_wake = |(flags & wake_en);
  assign wake_evt  = sleeping & pend_wake;
  assign irq       = ~sleeping & global_en & pend_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      global_en   <= 1'b0;
      sleeping    <= 1'b0;
      wake        <= 1'b0;
      wake_vector <= 1'b0;
    end else if (rst_req) begin
      global_en   <= 1'b0;
      sleeping    <= 1'b0;
      wake        <= 1'b0;
      wake_vector <= 1'b0;
    end else begin
      if (gie_clr || irq_ack) global_en <= 1'b0;
      else if (gie_set)       global_en <= 1'b1;
      wake        <= 1'b0;
      wake_vector <= 1'b0;
      if (sleeping) begin
        if (pend_wake) begin
          sleeping    <= 1'b0;
          wake        <= 1'b1;
          wake_vector <= global_en & pend_irq;
        end
      end else if (sleep_cmd) begin
        sleeping <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqw_checker.sv
module irqw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wdt_timeout,
  input logic [3:0] int_en,
  input logic [3:0] flag_clr,
  input logic [3:0] flags,
  input logic       irq,
  input logic       global_en,
  input logic       sleeping,
  input logic       wake,
  input logic       wake_vector,
  input logic       rst_req
);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (global_en && ((flags & int_en) != 4'b0)));

  assert_no_irq_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> !irq);

  assert_wake_from_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($past(sleeping) && !sleeping));

  assert_vector_with_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_vector |-> wake);

  assert_wdt_resets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> rst_req);

  assert_reset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (flags == 4'b0 && !sleeping && !global_en));

  assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));
endmodule

bind irq_wake_ctrl irqw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_timeout(wdt_timeout), .int_en(int_en),
  .flag_clr(flag_clr), .flags(flags), .irq(irq), .global_en(global_en),
  .sleeping(sleeping), .wake(wake), .wake_vector(wake_vector), .rst_req(rst_req));

// File: tb/sim_irq_wake_ctrl.sv
`timescale 1ns/1ps
module sim_irq_wake_ctrl;
  localparam int PW   = 8;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, rst_pin_n, wdt_timeout, port_rd, cmp_out;
  logic [PW-1:0] port_in;
  logic [1:0]    ext_pin_n;
  logic [3:0]    int_en, wake_en, flag_clr;
  logic          gie_set, gie_clr, irq_ack, sleep_cmd;
  logic [3:0]    flags;
  logic          irq, global_en, sleeping, wake, wake_vector, rst_req;
  logic [1:0]    rst_cause;

  irq_wake_ctrl #(.PORT_W(PW), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .wdt_timeout(wdt_timeout),
    .port_in(port_in), .port_rd(port_rd), .ext_pin_n(ext_pin_n), .cmp_out(cmp_out),
    .int_en(int_en), .wake_en(wake_en), .flag_clr(flag_clr), .gie_set(gie_set),
    .gie_clr(gie_clr), .irq_ack(irq_ack), .sleep_cmd(sleep_cmd), .flags(flags),
    .irq(irq), .global_en(global_en), .sleeping(sleeping), .wake(wake),
    .wake_vector(wake_vector), .rst_req(rst_req), .rst_cause(rst_cause));

  int checks = 0;
  int fails  = 0;
  logic [PW-1:0] port_v = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected values computed from the requirements.
  function automatic logic exp_wake(input logic slp, input logic we_b);
    return slp & we_b;
  endfunction
  function automatic logic exp_vec(input logic g, input logic ie_b);
    return g & ie_b;
  endfunction
  function automatic logic exp_irq(input logic slp, input logic we_b, input logic g, input logic ie_b);
    return ~(slp & ~we_b) & g & ie_b;
  endfunction

  task automatic wait_reset_done();
    for (int i = 0; i < 200; i++) begin
      if (!rst_req) break;
      @(negedge clk);
    end
  endtask

  task automatic fire(input int s);
    case (s)
      0: begin port_v = port_v ^ (PW'(1) << ($urandom % PW)); port_in = port_v; end
      1: ext_pin_n[0] = 1'b0;
      2: ext_pin_n[1] = 1'b0;
      default: cmp_out = ~cmp_out;
    endcase
  endtask

  task automatic run_case(input int s, input logic slp, input logic ie_b,
                          input logic we_b, input logic g);
    int wcnt;
    logic vec;
    string tag;
    tag = (s == 0) ? "R3" : (s == 3) ? "R5" : "R4";
    int_en  = 4'($urandom);  int_en[s]  = ie_b;
    wake_en = 4'($urandom);  wake_en[s] = we_b;
    if (g) gie_set = 1'b1; else gie_clr = 1'b1;
    cyc(1); gie_set = 1'b0; gie_clr = 1'b0;
    if (slp) begin
      sleep_cmd = 1'b1; cyc(1); sleep_cmd = 1'b0;
      chk("R9 enter sleep", sleeping, 1'b1);
    end
    fire(s);
    wcnt = 0; vec = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (wake) begin wcnt++; vec = wake_vector; end
    end
    chk({tag, " flag set"}, flags[s], 1'b1);
    chk("R9 wake count", wcnt, exp_wake(slp, we_b));
    chk("R9 still sleeping", sleeping, slp & ~we_b);
    chk("R7 irq level", irq, exp_irq(slp, we_b, g, ie_b));
    if (exp_wake(slp, we_b)) begin
      chk("R10 vector or continue", vec, exp_vec(g, ie_b));
      chk("R10 wake cause", rst_cause, 2'd3);
    end
    wake_en = 4'hf;
    ext_pin_n = 2'b11;
    port_rd = 1'b1; gie_clr = 1'b1; cyc(1); port_rd = 1'b0; gie_clr = 1'b0;
    cyc(4);
    flag_clr = 4'hf; cyc(1); flag_clr = 4'h0;
    cyc(2);
    chk("R6 flags cleared", flags, 4'h0);
    wake_en = 4'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd2024));
    rst_n = 1'b0; rst_pin_n = 1'b1; wdt_timeout = 1'b0; port_in = '0; port_rd = 1'b0;
    ext_pin_n = 2'b11; cmp_out = 1'b0; int_en = '0; wake_en = '0; flag_clr = '0;
    gie_set = 1'b0; gie_clr = 1'b0; irq_ack = 1'b0; sleep_cmd = 1'b0;
    cyc(3);
    chk("R1 rst_req in reset", rst_req, 1'b1);
    chk("R1 flags in reset", flags, 4'h0);
    chk("R1 irq in reset", irq, 1'b0);
    chk("R1 sleeping in reset", sleeping, 1'b0);
    chk("R1 cause power-on", rst_cause, 2'd0);
    rst_n = 1'b1;
    k = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); k++;
      if (!rst_req) break;
    end
    chk("R1 hold length", k, HOLD);
    chk("R1 global_en after reset", global_en, 1'b0);

    // R8: enable set, clear priority, acknowledge.
    gie_set = 1'b1; cyc(1); gie_set = 1'b0;
    chk("R8 set", global_en, 1'b1);
    gie_set = 1'b1; gie_clr = 1'b1; cyc(1); gie_set = 1'b0; gie_clr = 1'b0;
    chk("R8 clear wins", global_en, 1'b0);
    gie_set = 1'b1; cyc(1); gie_set = 1'b0;
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
    chk("R8 ack clears", global_en, 1'b0);

    // R3: clear does not stick until the port is read.
    port_v = 8'h5a; port_in = port_v; cyc(5);
    chk("R3 change flag", flags[0], 1'b1);
    flag_clr = 4'h1; cyc(1); flag_clr = 4'h0; cyc(2);
    chk("R3 re-set without read", flags[0], 1'b1);
    port_rd = 1'b1; cyc(1); port_rd = 1'b0;
    flag_clr = 4'h1; cyc(1); flag_clr = 4'h0; cyc(3);
    chk("R3 cleared after read", flags[0], 1'b0);

    // R4: a rising edge sets nothing.
    ext_pin_n[1] = 1'b0; cyc(5);
    chk("R4 ext1 falling", flags[2], 1'b1);
    flag_clr = 4'h4; cyc(1); flag_clr = 4'h0;
    ext_pin_n[1] = 1'b1; cyc(5);
    chk("R4 ext1 rising ignored", flags[2], 1'b0);

    // R6: event wins over a held clear.
    flag_clr = 4'h8; cmp_out = 1'b1; cyc(3);
    chk("R6 set wins over clear", flags[3], 1'b1);
    cyc(1);
    chk("R6 clear applied", flags[3], 1'b0);
    flag_clr = 4'h0;

    // Full grid: source x sleep x int enable x wake enable x global enable.
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 16; m++)
        run_case(s, m[3], m[2], m[1], m[0]);

    // R2: reset pin.
    cmp_out = ~cmp_out; cyc(5);
    chk("R5 flag before pin reset", flags[3], 1'b1);
    rst_pin_n = 1'b0; cyc(4);
    chk("R2 pin reset request", rst_req, 1'b1);
    chk("R2 pin cause", rst_cause, 2'd1);
    chk("R2 flags cleared by pin", flags, 4'h0);
    rst_pin_n = 1'b1; cyc(3);
    wait_reset_done();
    chk("R2 pin reset released", rst_req, 1'b0);

    // R2: watchdog.
    ext_pin_n[0] = 1'b0; cyc(5);
    chk("R4 ext0 flag before watchdog", flags[1], 1'b1);
    wdt_timeout = 1'b1; cyc(1); wdt_timeout = 1'b0;
    chk("R2 watchdog request", rst_req, 1'b1);
    chk("R2 watchdog cause", rst_cause, 2'd2);
    cyc(1);
    chk("R2 flags cleared by watchdog", flags, 4'h0);
    wait_reset_done();
    chk("R2 watchdog released", rst_req, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule